// File: doc/BRIEF.md
# Instruction Fetch Read Manager

This block supplies a 32-bit processor core with instruction words over the read half of an AXI4 manager port. It holds a fetch address that starts at a reset vector. It issues single-beat, word-aligned read requests at that address and at the words that follow. It does not wait for the core to ask for each word, and it keeps several reads in flight at once. The returned words go to the core in request order through a valid/ready handoff. Each word carries its address and a flag that marks an instruction access fault.

The core moves the fetch stream by pulsing a redirect with a new target address. The redirect empties the return buffer and starts fetching at the target. Reads issued before the redirect still return, and the block counts them and drops them as they arrive. The write address, write data and write response channels are present only so the port is complete, and they are always driven idle. Read data is always accepted. For that reason, new requests are held back whenever the return buffer could not take every read already in flight.

Top module: `ifetch_axi_mgr`

## Requirements
- R1: The write channels stay idle at all times: awvalid, wvalid and bready are 0. awaddr, wdata, wstrb and wlast are 0, awsize is 2, and awprot equals the PROT parameter.
- R2: Every read request has arsize = 2 (one 4-byte beat) and araddr bits [1:0] = 0. arprot always equals the PROT parameter (default 3'b100).
- R3: Once arvalid is high, it stays high and araddr stays unchanged in every following cycle until a cycle in which arready is sampled high.
- R4: Accepted read addresses rise in steps of 4 from the current stream start. This continues while the core is not taking instructions, and a redirect restarts the stream. The only exception is a request that was already waiting for arready when a redirect occurred: it still completes at its old address.
- R5: The number of accepted reads whose data has not returned never exceeds MAX_OUT (default 4). With a slow memory and a core that is always ready, the block reaches that limit.
- R6: rready is 1 at all times, so each cycle with rvalid high consumes one data beat.
- R7: The core receives the words of the current stream in address order. Each word has inst_addr equal to its fetch address and inst_data equal to the returned rdata. No word is lost or repeated.
- R8: inst_fault is 1 exactly for words whose read response had rresp not equal to 0.
- R9: A redirect cycle empties the return buffer, so inst_valid is 0 in the next cycle. Any handshake on the core side in that cycle does not count. The next word delivered has address {redir_addr[31:2], 2'b00}, and data returned for reads issued before the redirect is never delivered.
- R10: Live reads in flight plus buffered words never exceed BUF_DEPTH (default 4). If the core stalls, exactly BUF_DEPTH words of the stream are requested, and arvalid then stays low.
- R11: While reset is low, arvalid and inst_valid are 0 from the next clock edge on. The first request after reset is at {RESET_VEC[31:2], 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| redir_valid | input | 1 | One-cycle pulse that moves the fetch stream |
| redir_addr | input | 32 | Target of the redirect; low two bits ignored |
| inst_valid | output | 1 | An instruction word is offered to the core |
| inst_ready | input | 1 | The core takes the offered word |
| inst_addr | output | 32 | Fetch address of the offered word |
| inst_data | output | 32 | Instruction word |
| inst_fault | output | 1 | Access fault on this word |
| m_awvalid | output | 1 | Write address valid, held 0 |
| m_awready | input | 1 | Write address ready, ignored |
| m_awaddr | output | 32 | Write address, held 0 |
| m_awprot | output | 3 | Write protection, constant |
| m_awsize | output | 3 | Write size, constant 2 |
| m_wvalid | output | 1 | Write data valid, held 0 |
| m_wready | input | 1 | Write data ready, ignored |
| m_wdata | output | 32 | Write data, held 0 |
| m_wstrb | output | 4 | Write strobes, held 0 |
| m_wlast | output | 1 | Write last, held 0 |
| m_bvalid | input | 1 | Write response valid, ignored |
| m_bready | output | 1 | Write response ready, held 0 |
| m_bresp | input | 2 | Write response, ignored |
| m_arvalid | output | 1 | Read request valid |
| m_arready | input | 1 | Read request accepted |
| m_araddr | output | 32 | Word-aligned read address |
| m_arprot | output | 3 | Read protection, constant |
| m_arsize | output | 3 | Read size, constant 2 |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready, held 1 |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response; non-zero marks a fault |

## Verification
The assertions assume that the memory side returns read data only for requests it has accepted: rvalid never arrives while no read, live or stale, is in flight. They also assume it answers in the order of acceptance with a single beat per request. The bench's memory model queues each accepted address together with its acceptance cycle. It answers from the head of the queue after a chosen latency, one beat per cycle and never unprompted, and it clears the queue whenever the block is reset. The sweeps vary arready duty, core readiness and memory latency, with redirects to targets whose low bits are non-zero.

// File: rtl/ifetch_pkg.sv
// Shared types and helpers for the instruction fetch manager.
// Assumes a 32-bit address and instruction word.
package ifetch_pkg;

    localparam int XLEN = 32;

    // One returned instruction word as held in the return buffer
    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] data;
        logic            fault;
    } fetch_ent_t;

    // Clear the byte-offset bits of an address
    function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] a);
        return {a[XLEN-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/ifetch_track.sv
// Outstanding-read tracker.
// Counts accepted reads whose data has not returned yet. The count is split
// into live reads, whose data goes to the core, and stale reads, whose data
// is dropped. Responses come back in acceptance order, so every stale read
// returns before any live one. Provides next-state counts for the request
// throttle.
// Assumes: no rvalid while nothing is in flight; total in flight <= MAX_OUT.
module ifetch_track #(
    parameter int MAX_OUT = 4,
    localparam int CW     = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,     // redirect this cycle
    input  logic          ar_hs,     // read request accepted this cycle
    input  logic          ar_stale,  // the accepted request is stale
    input  logic          r_beat,    // read data beat this cycle
    output logic          r_live,    // the beat belongs to the current stream
    output logic [CW-1:0] live_n,
    output logic [CW-1:0] stale_n
);

    logic [CW-1:0] live_q;
    logic [CW-1:0] stale_q;
    logic          stale_busy;

    // Decide where this cycle's beat goes and compute next counts
    always_comb begin
        stale_busy = (stale_q != '0);
        r_live     = r_beat & ~stale_busy;
        if (flush) begin
            live_n  = '0;
            stale_n = stale_q + live_q + CW'(ar_hs) - CW'(r_beat);
        end else begin
            live_n  = live_q + CW'(ar_hs & ~ar_stale) - CW'(r_live);
            stale_n = stale_q + CW'(ar_hs & ar_stale) - CW'(r_beat & stale_busy);
        end
    end

    // Register the counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= '0;
            stale_q <= '0;
        end else begin
            live_q  <= live_n;
            stale_q <= stale_n;
        end
    end

    // R5
    out_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(live_q) + int'(stale_q)) <= MAX_OUT);

    // R6: input assumption, data only arrives for an accepted read
    beat_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_beat |-> (live_q != '0 || stale_q != '0));

endmodule

// File: rtl/ifetch_issue.sv
// Read request generator.
// Holds the next fetch address and drives arvalid/araddr. A request starts
// only when both the in-flight cap and the return-buffer space allow it.
// Once raised, a request is held with a fixed address until it is accepted.
// A redirect that comes while a request is held marks that request stale.
// Assumes: live_n, stale_n and cnt_n are the next-cycle counts.
module ifetch_issue
    import ifetch_pkg::*;
#(
    parameter int              MAX_OUT   = 4,
    parameter int              DEPTH     = 4,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0040,
    localparam int             CW        = $clog2(MAX_OUT + 1),
    localparam int             BW        = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [XLEN-1:0] flush_addr,
    input  logic            arready,
    input  logic [CW-1:0]   live_n,
    input  logic [CW-1:0]   stale_n,
    input  logic [BW-1:0]   cnt_n,
    output logic            arvalid,
    output logic [XLEN-1:0] araddr,
    output logic            ar_stale,
    output logic            ar_hs
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] base;
    logic            hold;
    logic            room;
    logic            launch;

    // Decide whether a new request may start in the next cycle
    always_comb begin
        ar_hs  = arvalid & arready;
        hold   = arvalid & ~arready;
        base   = flush ? word_align(flush_addr) : pc_q;
        room   = ((int'(live_n) + int'(stale_n)) < MAX_OUT) &&
                 ((int'(live_n) + int'(cnt_n)) < DEPTH);
        launch = ~hold & room;
    end

    // Request register and fetch address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arvalid  <= 1'b0;
            araddr   <= '0;
            ar_stale <= 1'b0;
            pc_q     <= word_align(RESET_VEC);
        end else if (launch) begin
            arvalid  <= 1'b1;
            araddr   <= base;
            ar_stale <= 1'b0;
            pc_q     <= base + XLEN'(4);
        end else if (hold) begin
            ar_stale <= ar_stale | flush;
            pc_q     <= base;
        end else begin
            arvalid  <= 1'b0;
            ar_stale <= 1'b0;
            pc_q     <= base;
        end
    end

    // R3
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr)));

    // R2
    ar_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> (araddr[1:0] == 2'b00));

endmodule

// File: rtl/ifetch_rbuf.sv
// Return buffer: an in-order circular queue of fetched words.
// Push and pop may happen in the same cycle. A flush empties the queue and
// takes priority over push and pop.
// Assumes: the request throttle never lets a push hit a full queue.
module ifetch_rbuf
    import ifetch_pkg::*;
#(
    parameter int  DEPTH = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  fetch_ent_t    push_ent,
    input  logic          pop,
    output logic          out_valid,
    output fetch_ent_t    out_ent,
    output logic [BW-1:0] cnt_n
);

    fetch_ent_t    slots [DEPTH];
    logic [PW-1:0] wr_q;
    logic [PW-1:0] rd_q;
    logic [BW-1:0] cnt_q;
    logic          push_eff;
    logic          pop_eff;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Effective operations and next occupancy
    always_comb begin
        out_valid = (cnt_q != '0);
        out_ent   = slots[rd_q];
        push_eff  = push & ~flush;
        pop_eff   = pop & out_valid & ~flush;
        cnt_n     = flush ? '0 : cnt_q + BW'(push_eff) - BW'(pop_eff);
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_eff) wr_q <= bump(wr_q);
            if (pop_eff)  rd_q <= bump(rd_q);
            cnt_q <= cnt_n;
        end
    end

    // One write port per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the incoming word when this slot is the write target
        always_ff @(posedge clk) begin
            if (push_eff && wr_q == PW'(g)) slots[g] <= push_ent;
        end
    end

    // R10
    buf_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_eff && !pop_eff) |-> (int'(cnt_q) < DEPTH));

endmodule

// File: rtl/ifetch_axi_mgr.sv
// Instruction fetch manager on the read side of an AXI4 manager port.
// Issues single-beat word reads ahead of the core, tracks reads in flight,
// drops data from reads made stale by a redirect, and hands words to the
// core in order, each with a fault flag taken from rresp.
// Assumes: in-order single-beat responses, none without a matching request.
module ifetch_axi_mgr
    import ifetch_pkg::*;
#(
    parameter int              MAX_OUT   = 4,
    parameter int              BUF_DEPTH = 4,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0040,
    parameter logic [2:0]      PROT      = 3'b100,
    localparam int             EFF_DEPTH = (BUF_DEPTH < MAX_OUT) ? MAX_OUT : BUF_DEPTH,
    localparam int             CW        = $clog2(MAX_OUT + 1),
    localparam int             BW        = $clog2(EFF_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redir_valid,
    input  logic [XLEN-1:0] redir_addr,
    output logic            inst_valid,
    input  logic            inst_ready,
    output logic [XLEN-1:0] inst_addr,
    output logic [XLEN-1:0] inst_data,
    output logic            inst_fault,
    output logic            m_awvalid,
    input  logic            m_awready,
    output logic [XLEN-1:0] m_awaddr,
    output logic [2:0]      m_awprot,
    output logic [2:0]      m_awsize,
    output logic            m_wvalid,
    input  logic            m_wready,
    output logic [XLEN-1:0] m_wdata,
    output logic [3:0]      m_wstrb,
    output logic            m_wlast,
    input  logic            m_bvalid,
    output logic            m_bready,
    input  logic [1:0]      m_bresp,
    output logic            m_arvalid,
    input  logic            m_arready,
    output logic [XLEN-1:0] m_araddr,
    output logic [2:0]      m_arprot,
    output logic [2:0]      m_arsize,
    input  logic            m_rvalid,
    output logic            m_rready,
    input  logic [XLEN-1:0] m_rdata,
    input  logic [1:0]      m_rresp
);

    logic            ar_hs;
    logic            ar_stale;
    logic            r_live;
    logic [CW-1:0]   live_n;
    logic [CW-1:0]   stale_n;
    logic [BW-1:0]   cnt_n;
    logic [XLEN-1:0] resp_pc_q;
    fetch_ent_t      push_ent;
    fetch_ent_t      head_ent;
    logic            unused_wr_in;

    // Idle write channels and fixed read attributes
    assign m_awvalid    = 1'b0;
    assign m_awaddr     = '0;
    assign m_awprot     = PROT;
    assign m_awsize     = 3'd2;
    assign m_wvalid     = 1'b0;
    assign m_wdata      = '0;
    assign m_wstrb      = '0;
    assign m_wlast      = 1'b0;
    assign m_bready     = 1'b0;
    assign m_arprot     = PROT;
    assign m_arsize     = 3'd2;
    assign m_rready     = 1'b1;
    assign unused_wr_in = ^{m_awready, m_wready, m_bvalid, m_bresp};

    ifetch_issue #(
        .MAX_OUT   (MAX_OUT),
        .DEPTH     (EFF_DEPTH),
        .RESET_VEC (RESET_VEC)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (redir_valid),
        .flush_addr (redir_addr),
        .arready    (m_arready),
        .live_n     (live_n),
        .stale_n    (stale_n),
        .cnt_n      (cnt_n),
        .arvalid    (m_arvalid),
        .araddr     (m_araddr),
        .ar_stale   (ar_stale),
        .ar_hs      (ar_hs)
    );

    ifetch_track #(
        .MAX_OUT (MAX_OUT)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (redir_valid),
        .ar_hs    (ar_hs),
        .ar_stale (ar_stale),
        .r_beat   (m_rvalid),
        .r_live   (r_live),
        .live_n   (live_n),
        .stale_n  (stale_n)
    );

    // Address of the next live response in the current stream
    always_ff @(posedge clk) begin
        if (!rst_n)           resp_pc_q <= word_align(RESET_VEC);
        else if (redir_valid) resp_pc_q <= word_align(redir_addr);
        else if (r_live)      resp_pc_q <= resp_pc_q + XLEN'(4);
    end

    // Tag the returning beat with its address and fault flag
    always_comb begin
        push_ent.addr  = resp_pc_q;
        push_ent.data  = m_rdata;
        push_ent.fault = (m_rresp != 2'b00);
    end

    ifetch_rbuf #(
        .DEPTH (EFF_DEPTH)
    ) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redir_valid),
        .push      (r_live),
        .push_ent  (push_ent),
        .pop       (inst_ready),
        .out_valid (inst_valid),
        .out_ent   (head_ent),
        .cnt_n     (cnt_n)
    );

    // Present the head of the buffer to the core
    always_comb begin
        inst_addr  = head_ent.addr;
        inst_data  = head_ent.data;
        inst_fault = head_ent.fault;
    end

    // R9
    redir_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !inst_valid);

    // R7
    deliver_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inst_valid |-> (inst_addr[1:0] == 2'b00));

endmodule

// File: tb/test_ifetch_axi_mgr.sv
`timescale 1ns/1ps
module test_ifetch_axi_mgr;

    localparam int          MAXO  = 4;
    localparam int          DEPTH = 4;
    localparam logic [31:0] RVEC  = 32'h0000_0040;
    localparam logic [2:0]  PROT  = 3'b100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_addr = '0;
    logic        inst_valid, inst_fault;
    logic        inst_ready = 1'b0;
    logic [31:0] inst_addr, inst_data;
    logic        m_awvalid, m_wvalid, m_wlast, m_bready, m_arvalid, m_rready;
    logic [31:0] m_awaddr, m_wdata, m_araddr;
    logic [2:0]  m_awprot, m_awsize, m_arprot, m_arsize;
    logic [3:0]  m_wstrb;
    logic        m_arready = 1'b0;
    logic        m_rvalid = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [1:0]  m_rresp = '0;

    always #2.5 clk = ~clk;

    ifetch_axi_mgr #(.MAX_OUT(MAXO), .BUF_DEPTH(DEPTH), .RESET_VEC(RVEC), .PROT(PROT))
    i_ifetch_axi_mgr (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .inst_valid(inst_valid), .inst_ready(inst_ready), .inst_addr(inst_addr),
        .inst_data(inst_data), .inst_fault(inst_fault),
        .m_awvalid(m_awvalid), .m_awready(1'b1), .m_awaddr(m_awaddr), .m_awprot(m_awprot),
        .m_awsize(m_awsize), .m_wvalid(m_wvalid), .m_wready(1'b1), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(1'b0), .m_bready(m_bready),
        .m_bresp(2'b00), .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_arprot(m_arprot), .m_arsize(m_arsize), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .m_rdata(m_rdata), .m_rresp(m_rresp)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // memory model queue
    logic [31:0] q_addr [16];
    int          q_time [16];
    int          q_head, q_num;

    // expectation state
    logic [31:0] exp_pc, exp_ar, prev_addr;
    bit          skip_ar, prev_hold, prev_redir, first_ar;
    int          out_cnt, max_out, s_iss, s_del, max_diff, n_del;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h3C00_00A5;
    endfunction

    function automatic bit mem_fault(input logic [31:0] a);
        return a[6:4] == 3'b101;
    endfunction

    function automatic bit pat(input int p, input int c);
        case (p)
            0:       return 1'b1;
            1:       return (c % 3) != 0;
            default: return (c % 4) == 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic clear_stats;
        max_out = 0; max_diff = 0; n_del = 0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; m_arready = 1'b0; m_rvalid = 1'b0;
        inst_ready = 1'b0; redir_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!m_arvalid, "R11", "arvalid in reset", 32'(m_arvalid), 32'h0);
        chk(!inst_valid, "R11", "inst_valid in reset", 32'(inst_valid), 32'h0);
        q_head = 0; q_num = 0;
        exp_pc = RVEC; exp_ar = RVEC; skip_ar = 0; prev_hold = 0; prev_redir = 0;
        first_ar = 1; out_cnt = 0; s_iss = 0; s_del = 0;
        clear_stats();
        rst_n = 1'b1;
    endtask

    // one cycle: observe at the falling edge, then drive the next inputs
    task automatic step(input bit ar_rdy, input bit in_rdy, input int lat,
                        input bit do_redir, input logic [31:0] tgt);
        bit hs, beat;
        @(negedge clk);
        // R1
        chk(!m_awvalid && !m_wvalid && !m_bready && m_awaddr == 0 && m_wdata == 0 &&
            m_wstrb == 0 && !m_wlast && m_awsize == 3'd2 && m_awprot == PROT,
            "R1", "write channels idle", {m_awvalid, m_wvalid, m_bready}, 32'h0);
        // R6
        chk(m_rready, "R6", "rready", 32'(m_rready), 32'h1);
        // R2
        chk(m_arsize == 3'd2 && m_arprot == PROT && (!m_arvalid || m_araddr[1:0] == 2'b00),
            "R2", "read attributes", {m_arsize, m_arprot, m_araddr[1:0]},
            {3'd2, PROT, 2'b00});
        // R3
        if (prev_hold)
            chk(m_arvalid && m_araddr == prev_addr, "R3", "held request",
                m_araddr, prev_addr);
        // R9
        if (prev_redir)
            chk(!inst_valid, "R9", "buffer empty after redirect",
                32'(inst_valid), 32'h0);
        // core side
        inst_ready = in_rdy & ~do_redir;
        if (inst_valid && inst_ready) begin
            // R7
            chk(inst_addr == exp_pc && inst_data == mem_word(exp_pc), "R7",
                "delivered word", inst_addr, exp_pc);
            // R8
            chk(inst_fault == mem_fault(exp_pc), "R8", "fault flag",
                32'(inst_fault), 32'(mem_fault(exp_pc)));
            exp_pc = exp_pc + 4; s_del++; n_del++;
        end
        // read data
        beat = 0;
        if (q_num > 0 && (cyc - q_time[q_head]) >= lat) begin
            beat = 1;
            m_rdata = mem_word(q_addr[q_head]);
            m_rresp = mem_fault(q_addr[q_head]) ? 2'b10 : 2'b00;
            q_head = (q_head + 1) % 16; q_num--;
        end
        m_rvalid = beat;
        // read request
        m_arready = ar_rdy;
        hs = m_arvalid && ar_rdy;
        if (hs) begin
            q_addr[(q_head + q_num) % 16] = m_araddr;
            q_time[(q_head + q_num) % 16] = cyc;
            q_num++;
            if (skip_ar) skip_ar = 0;
            else begin
                // R4 / R11
                chk(m_araddr == exp_ar, first_ar ? "R11" : "R4", "request address",
                    m_araddr, exp_ar);
                exp_ar = exp_ar + 4; s_iss++;
            end
            first_ar = 0;
        end
        out_cnt = out_cnt + int'(hs) - int'(beat);
        if (out_cnt > max_out) max_out = out_cnt;
        if (s_iss - s_del > max_diff) max_diff = s_iss - s_del;
        prev_hold = m_arvalid && !ar_rdy;
        prev_addr = m_araddr;
        // redirect
        redir_valid = do_redir;
        redir_addr = tgt;
        if (do_redir) begin
            skip_ar = m_arvalid && !ar_rdy;
            exp_ar = {tgt[31:2], 2'b00};
            exp_pc = {tgt[31:2], 2'b00};
            s_iss = 0; s_del = 0;
        end
        prev_redir = do_redir;
        cyc++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, 150000);
        summary();
    end

    initial begin
        int lats [3] = '{1, 3, 6};
        logic [31:0] tgt;
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 2, 1'b0, 32'h0);
        chk(n_del > 0, "R11", "fetching from reset vector", 32'(n_del), 32'h1);

        // sweep arready duty x core readiness x latency, two redirects each
        for (int ap = 0; ap < 3; ap++)
            for (int ip = 0; ip < 3; ip++)
                for (int li = 0; li < 3; li++) begin
                    int ph = ap * 9 + ip * 3 + li;
                    tgt = 32'h1000 + 32'(ph) * 32'h64 + 32'(ph % 4);
                    clear_stats();
                    for (int c = 0; c < 80; c++)
                        step(pat(ap, cyc), pat(ip, cyc + 1), lats[li], c == 0 || c == 40,
                             c == 0 ? tgt : tgt + 32'h200 + 32'(ph % 3));
                    // R5
                    chk(max_out <= MAXO, "R5", "reads in flight", 32'(max_out), 32'(MAXO));
                    // R10
                    chk(max_diff <= DEPTH, "R10", "live plus buffered",
                        32'(max_diff), 32'(DEPTH));
                    // R7
                    chk(n_del > 0, "R7", "progress", 32'(n_del), 32'h1);
                    if (ap == 0 && ip == 0 && li == 2)
                        chk(max_out == MAXO, "R5", "cap reached with slow memory",
                            32'(max_out), 32'(MAXO));
                end

        // stalled core: exactly DEPTH words requested, then no request
        step(1'b1, 1'b0, 1, 1'b1, 32'h0000_2002);
        for (int c = 0; c < 30; c++) step(1'b1, 1'b0, 1, 1'b0, 32'h0);
        chk(s_iss == DEPTH, "R10", "requests while stalled", 32'(s_iss), 32'(DEPTH));
        chk(!m_arvalid, "R10", "arvalid low while stalled", 32'(m_arvalid), 32'h0);
        clear_stats();
        for (int c = 0; c < 30; c++) step(1'b1, 1'b1, 1, 1'b0, 32'h0);
        chk(n_del >= 12, "R4", "stream resumes after stall", 32'(n_del), 32'd12);

        // mid-run reset
        do_reset();
        for (int c = 0; c < 30; c++) step(pat(1, cyc), 1'b1, 3, 1'b0, 32'h0);
        chk(n_del > 0, "R11", "restart after reset", 32'(n_del), 32'h1);
        @(negedge clk);
        summary();
    end

endmodule